// File: doc/BRIEF.md
# SD Multi-Lane Data Receiver

This block captures data blocks arriving on the four SD data lines, in either single-lane or four-lane mode. A command receiver supplies four inputs ahead of each transfer: a flag that says a block is expected, the block length in bytes, the bus width and a write flag. The block waits for a low start bit on every active lane and then shifts in the payload. It checks a separate CRC16 on each active lane and samples the end bit. The payload leaves the block as a byte stream with a one-cycle valid strobe.

When the last end bit has been sampled, a done strobe reports whether every lane CRC matched and whether the end bit was high. On a write, the block then watches DAT0 for the card's short CRC status token and reports its 3-bit pattern as accepted, CRC error or malformed. Each clock cycle is one bit time on the lines.

Top module: `sd_dat_rx`

## Requirements
- R1: After reset, byte_valid_o, done_o and tok_valid_o are low, and they stay low while the lines idle high.
- R2: A block is captured only if data_exp_i is high in the cycle the start bit is sampled. With data_exp_i low, a complete frame produces no byte and no done strobe.
- R3: In single-lane mode (wide_i=0), each byte arrives on DAT0 with the most significant bit first, and blk_len_i bytes are delivered. DAT1 to DAT3 are ignored.
- R4: In four-lane mode (wide_i=1), each bit time carries a nibble with DAT3 as its most significant bit. The first nibble of a byte is its high nibble.
- R5: Each received byte is output on byte_o together with a single-cycle byte_valid_o pulse. A block yields exactly blk_len_i pulses.
- R6: Each active lane carries a 16-bit CRC after its data bits. The CRC uses the polynomial x^16+x^12+x^5+1 (0x1021), is initialised to zero, and is sent MSB first. It covers that lane's data bits only. crc_ok_o is high only if the CRC of every active lane matches.
- R7: end_ok_o is high only if the bit after the CRC is 1 on every active lane.
- R8: done_o is a single-cycle pulse in the cycle after the end bit is sampled. crc_ok_o and end_ok_o are valid with it.
- R9: After a write block, the block captures a start bit, three status bits (first bit = MSB) and an end bit on DAT0. It then pulses tok_valid_o with exactly one flag set: tok_accept_o for 010, tok_crc_err_o for 101, and tok_err_o for any other pattern or for a low end bit.
- R10: After a read block (write_i=0), no status token is captured and tok_valid_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one line bit per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dat_i | input | 4 | DAT3..DAT0 line levels |
| data_exp_i | input | 1 | A data block is expected |
| wide_i | input | 1 | 1 selects four-lane mode |
| write_i | input | 1 | Block is a write; a status token follows |
| blk_len_i | input | LEN_W | Block length in bytes |
| byte_o | output | 8 | Received byte |
| byte_valid_o | output | 1 | byte_o valid, one cycle |
| done_o | output | 1 | Block finished, one cycle |
| crc_ok_o | output | 1 | All active lane CRCs matched |
| end_ok_o | output | 1 | End bit high on all active lanes |
| tok_valid_o | output | 1 | Status token captured, one cycle |
| tok_accept_o | output | 1 | Token was 010 |
| tok_crc_err_o | output | 1 | Token was 101 |
| tok_err_o | output | 1 | Token malformed |

## Verification
The hardest case to reach is a CRC failure that is confined to one lane while the other three lanes stay correct, because any encoder the bench would normally use produces consistent CRCs on every lane. The bench therefore computes each lane's CRC itself and flips a single CRC bit on one chosen lane. It sweeps that lane through all four positions, so the per-lane comparison and the merge of the lane results are both exercised. A second case is junk on the unused lanes in single-lane mode: the bench toggles DAT1 to DAT3 during the data and CRC phases and expects bytes and CRC to be unaffected.

// File: rtl/sd_rx_pkg.sv
package sd_rx_pkg;
  localparam int unsigned LANES    = 4;
  localparam int unsigned CRC_W    = 16;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_CRC,
    ST_END
  } rx_state_e;

  typedef enum logic [1:0] {
    TK_IDLE,
    TK_WAIT,
    TK_BITS,
    TK_END
  } tok_state_e;
endpackage

// File: rtl/sd_crc16_lane.sv
module sd_crc16_lane
  import sd_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic shift_i,
  input  logic bit_i,
  output logic match_o
);
  logic [CRC_W-1:0] calc_q, rx_q, calc_nxt;
  logic fb;

  always_comb begin
    fb       = bit_i ^ calc_q[CRC_W-1];
    calc_nxt = {calc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      calc_q <= '0;
      rx_q   <= '0;
    end else if (clr_i) begin
      calc_q <= '0;
      rx_q   <= '0;
    end else if (en_i) begin
      calc_q <= calc_nxt;
    end else if (shift_i) begin
      rx_q <= {rx_q[CRC_W-2:0], bit_i};
    end
  end

  assign match_o = (calc_q == rx_q);

  AST_CRC_PHASE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && shift_i)); // R6
  AST_CRC_CLR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !en_i && !shift_i); // R6
endmodule

// File: rtl/sd_lane_merge.sv
module sd_lane_merge
  import sd_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             wide_i,
  input  logic [LANES-1:0] dat_i,
  output logic [7:0]       byte_o,
  output logic             byte_valid_o
);
  logic [7:0] sh_q, sh_nxt;
  logic [2:0] cnt_q;
  logic       last;

  always_comb begin
    sh_nxt = wide_i ? {sh_q[3:0], dat_i} : {sh_q[6:0], dat_i[0]};
    last   = wide_i ? cnt_q[0] : (cnt_q == 3'd7);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q         <= '0;
      cnt_q        <= '0;
      byte_o       <= '0;
      byte_valid_o <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (en_i) begin
        sh_q  <= sh_nxt;
        cnt_q <= last ? 3'd0 : cnt_q + 3'd1;
        if (last) begin
          byte_o       <= sh_nxt;
          byte_valid_o <= 1'b1;
        end
      end
    end
  end

  AST_BYTE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o); // R5
endmodule

// File: rtl/sd_tok_rx.sv
module sd_tok_rx
  import sd_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic dat0_i,
  output logic busy_o,
  output logic tok_valid_o,
  output logic tok_accept_o,
  output logic tok_crc_err_o,
  output logic tok_err_o
);
  tok_state_e  state_q;
  logic [2:0]  sh_q;
  logic [1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= TK_IDLE;
      sh_q          <= '0;
      cnt_q         <= '0;
      tok_valid_o   <= 1'b0;
      tok_accept_o  <= 1'b0;
      tok_crc_err_o <= 1'b0;
      tok_err_o     <= 1'b0;
    end else begin
      tok_valid_o   <= 1'b0;
      tok_accept_o  <= 1'b0;
      tok_crc_err_o <= 1'b0;
      tok_err_o     <= 1'b0;
      unique case (state_q)
        TK_IDLE: if (arm_i) state_q <= TK_WAIT;
        TK_WAIT: if (!dat0_i) begin
          state_q <= TK_BITS;
          cnt_q   <= 2'd3;
        end
        TK_BITS: begin
          sh_q  <= {sh_q[1:0], dat0_i};
          cnt_q <= cnt_q - 2'd1;
          if (cnt_q == 2'd1) state_q <= TK_END;
        end
        TK_END: begin
          state_q       <= TK_IDLE;
          tok_valid_o   <= 1'b1;
          tok_accept_o  <= dat0_i && (sh_q == 3'b010);
          tok_crc_err_o <= dat0_i && (sh_q == 3'b101);
          tok_err_o     <= !dat0_i || !((sh_q == 3'b010) || (sh_q == 3'b101));
        end
        default: state_q <= TK_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != TK_IDLE);

  AST_TOK_ONE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_valid_o |-> $onehot({tok_accept_o, tok_crc_err_o, tok_err_o})); // R9
  AST_TOK_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_valid_o |-> $past(state_q == TK_END)); // R9
endmodule

// File: rtl/sd_dat_rx.sv
module sd_dat_rx
  import sd_rx_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 512,
  localparam int unsigned LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int unsigned CNT_W    = $clog2(MAX_BYTES * 8 + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       dat_i,
  input  logic             data_exp_i,
  input  logic             wide_i,
  input  logic             write_i,
  input  logic [LEN_W-1:0] blk_len_i,
  output logic [7:0]       byte_o,
  output logic             byte_valid_o,
  output logic             done_o,
  output logic             crc_ok_o,
  output logic             end_ok_o,
  output logic             tok_valid_o,
  output logic             tok_accept_o,
  output logic             tok_crc_err_o,
  output logic             tok_err_o
);
  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q, len_bits;
  logic [LANES-1:0] mask_q, mask_in, lane_match;
  logic             wide_q, wr_q, start_hit, tok_busy;

  assign mask_in  = wide_i ? {LANES{1'b1}} : LANES'(1);
  assign len_bits = wide_i ? (CNT_W'(blk_len_i) << 1) : (CNT_W'(blk_len_i) << 3);
  assign start_hit = (state_q == ST_IDLE) && !tok_busy && data_exp_i
                     && ((dat_i & mask_in) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      mask_q   <= '0;
      wide_q   <= 1'b0;
      wr_q     <= 1'b0;
      done_o   <= 1'b0;
      crc_ok_o <= 1'b0;
      end_ok_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_hit) begin
          mask_q <= mask_in;
          wide_q <= wide_i;
          wr_q   <= write_i;
          if (len_bits == '0) begin
            state_q <= ST_CRC;
            cnt_q   <= CNT_W'(CRC_W);
          end else begin
            state_q <= ST_DATA;
            cnt_q   <= len_bits;
          end
        end
        ST_DATA: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) begin
            state_q <= ST_CRC;
            cnt_q   <= CNT_W'(CRC_W);
          end
        end
        ST_CRC: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) state_q <= ST_END;
        end
        ST_END: begin
          state_q  <= ST_IDLE;
          done_o   <= 1'b1;
          crc_ok_o <= &(lane_match | ~mask_q);
          end_ok_o <= &(dat_i | ~mask_q);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sd_crc16_lane i_crc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (start_hit),
      .en_i    (state_q == ST_DATA),
      .shift_i (state_q == ST_CRC),
      .bit_i   (dat_i[g]),
      .match_o (lane_match[g])
    );
  end

  sd_lane_merge i_merge (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (start_hit),
    .en_i         (state_q == ST_DATA),
    .wide_i       (wide_q),
    .dat_i        (dat_i),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o)
  );

  sd_tok_rx i_tok (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .arm_i         ((state_q == ST_END) && wr_q),
    .dat0_i        (dat_i[0]),
    .busy_o        (tok_busy),
    .tok_valid_o   (tok_valid_o),
    .tok_accept_o  (tok_accept_o),
    .tok_crc_err_o (tok_crc_err_o),
    .tok_err_o     (tok_err_o)
  );

  AST_BYTE_IN_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> $past(state_q == ST_DATA)); // R5
  AST_DONE_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(state_q == ST_END)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_NO_UNEXPECTED_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !data_exp_i) |=> state_q == ST_IDLE); // R2
  AST_NO_TOK_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_END && !wr_q) |=> !tok_busy); // R10
endmodule

// File: tb/test_sd_dat_rx.sv
module test_sd_dat_rx;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] dat_i = 4'hF;
  logic       data_exp_i = 1'b0, wide_i = 1'b0, write_i = 1'b0;
  logic [9:0] blk_len_i = '0;
  logic [7:0] byte_o;
  logic       byte_valid_o, done_o, crc_ok_o, end_ok_o;
  logic       tok_valid_o, tok_accept_o, tok_crc_err_o, tok_err_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] tx [16];
  logic [7:0] rx [16];
  int rx_n = 0, done_n = 0, tok_n = 0;
  logic d_crc, d_end, t_acc, t_crc, t_err;

  always #10 clk_i = ~clk_i;

  sd_dat_rx i_sd_dat_rx (
    .clk_i, .rst_ni, .dat_i, .data_exp_i, .wide_i, .write_i, .blk_len_i,
    .byte_o, .byte_valid_o, .done_o, .crc_ok_o, .end_ok_o,
    .tok_valid_o, .tok_accept_o, .tok_crc_err_o, .tok_err_o
  );

  always @(negedge clk_i) begin
    if (byte_valid_o) begin
      if (rx_n < 16) rx[rx_n] = byte_o;
      rx_n++;
    end
    if (done_o) begin
      done_n++;
      d_crc = crc_ok_o;
      d_end = end_ok_o;
    end
    if (tok_valid_o) begin
      tok_n++;
      t_acc = tok_accept_o;
      t_crc = tok_crc_err_o;
      t_err = tok_err_o;
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb = b ^ c[15];
    return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction

  // bad_lane: lane whose CRC bit 5 is flipped (-1 none); junk: toggle unused lanes
  task automatic run_block(input bit wide, input int len, input int seed, input int bad_lane,
                           input bit bad_end, input bit wr, input logic [2:0] tok,
                           input bit exp, input bit junk);
    logic [15:0] c [4];
    logic [3:0] d;
    int per = wide ? 2 : 8;
    for (int l = 0; l < 4; l++) c[l] = '0;
    for (int i = 0; i < len; i++) tx[i] = 8'((i * 53 + seed * 29 + 7) & 255);
    @(negedge clk_i);
    rx_n = 0; done_n = 0; tok_n = 0;
    data_exp_i = exp; wide_i = wide; write_i = wr; blk_len_i = 10'(len);
    dat_i = wide ? 4'h0 : 4'hE;
    @(negedge clk_i);
    for (int i = 0; i < len; i++) begin
      for (int p = 0; p < per; p++) begin
        if (wide) d = p == 0 ? tx[i][7:4] : tx[i][3:0];
        else d = {junk ? 3'(p + i) : 3'b111, tx[i][7 - p]};
        for (int l = 0; l < 4; l++) c[l] = crc_step(c[l], d[l]);
        dat_i = d;
        @(negedge clk_i);
      end
    end
    for (int k = 0; k < 16; k++) begin
      for (int l = 0; l < 4; l++) d[l] = c[l][15 - k] ^ (l == bad_lane && k == 5);
      if (!wide) d[3:1] = junk ? 3'(k) : 3'b111;
      dat_i = d;
      @(negedge clk_i);
    end
    dat_i = bad_end ? (wide ? 4'b1011 : 4'hE) : 4'hF;
    @(negedge clk_i);
    dat_i = 4'hF; data_exp_i = 1'b0;
    if (wr) begin
      repeat (2) @(negedge clk_i);
      dat_i = 4'hE; @(negedge clk_i);
      for (int b = 2; b >= 0; b--) begin dat_i = {3'b111, tok[b]}; @(negedge clk_i); end
      dat_i = 4'hF;
    end
    repeat (4) @(negedge clk_i);
  endtask

  task automatic check_data(input bit wide, input int len, input string tag);
    int bad = 0;
    chk(rx_n == len, "R5", {tag, " byte count"}, rx_n, len);
    for (int i = 0; i < len && i < rx_n; i++) if (rx[i] !== tx[i]) bad++;
    chk(bad == 0, wide ? "R4" : "R3", {tag, " byte mismatches"}, bad, 0);
    chk(done_n == 1, "R8", {tag, " done pulses"}, done_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!byte_valid_o && !done_o && !tok_valid_o, "R1", "reset outputs", int'(byte_valid_o), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk(rx_n == 0 && done_n == 0 && tok_n == 0, "R1", "idle quiet", rx_n + done_n, 0);

    // clean blocks, both widths, lengths 1..4, two seeds
    for (int w = 0; w < 2; w++)
      for (int len = 1; len <= 4; len++)
        for (int s = 0; s < 2; s++) begin
          run_block(w[0], len, s + len, -1, 1'b0, 1'b0, 3'b000, 1'b1, 1'b0);
          check_data(w[0], len, "clean");
          chk(d_crc == 1'b1, "R6", "clean crc_ok", int'(d_crc), 1);
          chk(d_end == 1'b1, "R7", "clean end_ok", int'(d_end), 1);
          chk(tok_n == 0, "R10", "no token on read", tok_n, 0);
        end

    // single-lane CRC error per active lane; in four-lane mode each lane
    for (int l = 0; l < 4; l++) begin
      run_block(1'b1, 3, l, l, 1'b0, 1'b0, 3'b000, 1'b1, 1'b0);
      check_data(1'b1, 3, "lane crc err");
      chk(d_crc == 1'b0, "R6", "4-lane bad lane crc_ok", int'(d_crc), 0);
      chk(d_end == 1'b1, "R7", "4-lane bad crc end_ok", int'(d_end), 1);
    end
    run_block(1'b0, 2, 9, 0, 1'b0, 1'b0, 3'b000, 1'b1, 1'b0);
    chk(d_crc == 1'b0, "R6", "1-lane bad crc_ok", int'(d_crc), 0);

    // unused lanes toggling in single-lane mode
    run_block(1'b0, 4, 5, -1, 1'b0, 1'b0, 3'b000, 1'b1, 1'b1);
    check_data(1'b0, 4, "junk lanes R3");
    chk(d_crc == 1'b1, "R6", "junk lanes crc_ok", int'(d_crc), 1);

    // bad end bit
    for (int w = 0; w < 2; w++) begin
      run_block(w[0], 2, 3, -1, 1'b1, 1'b0, 3'b000, 1'b1, 1'b0);
      chk(d_end == 1'b0, "R7", "bad end_ok", int'(d_end), 0);
      chk(d_crc == 1'b1, "R6", "bad end crc_ok", int'(d_crc), 1);
    end

    // data_exp low: frame ignored
    for (int w = 0; w < 2; w++) begin
      run_block(w[0], 2, 4, -1, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0);
      chk(rx_n == 0, "R2", "unexpected frame bytes", rx_n, 0);
      chk(done_n == 0, "R2", "unexpected frame done", done_n, 0);
    end

    // write tokens, every pattern
    for (int t = 0; t < 8; t++) begin
      logic [2:0] tk = 3'(t);
      run_block(t[0], 2, t, -1, 1'b0, 1'b1, tk, 1'b1, 1'b0);
      check_data(t[0], 2, "write");
      chk(tok_n == 1, "R9", "token count", tok_n, 1);
      chk(t_acc == (tk == 3'b010), "R9", "tok_accept", int'(t_acc), int'(tk == 3'b010));
      chk(t_crc == (tk == 3'b101), "R9", "tok_crc_err", int'(t_crc), int'(tk == 3'b101));
      chk(t_err == !(tk == 3'b010 || tk == 3'b101), "R9", "tok_err", int'(t_err),
          int'(!(tk == 3'b010 || tk == 3'b101)));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule